// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block exchanges bytes between time slots of several parallel TDM streams. In every channel slot it takes one byte per stream from two groups of input streams, a local group and an alternate group. It stores these bytes in a double-buffered data memory, addressed by buffer, group, stream and channel. In the same slot it produces one byte per output stream. A connection memory holds one 16-bit control word and one 16-bit sub-rate word for every output stream and channel. The control word decides whether the slot carries a switched byte from any stored stream and channel, a fixed message byte taken from the word itself, or nothing at all (driver off).

The stream rate is set by a static mode input: 32, 64 or 128 channels per frame, or a 32-channel sub-rate mode. In sub-rate mode each switched byte is reduced to one chosen 2-bit field. Each output slot picks its own delay behaviour. Constant delay always returns the byte stored one frame earlier. Variable delay returns this frame's byte when the source channel came earlier in the frame, and last frame's byte otherwise. Software loads the connection memory through a simple write port, and writes take effect from the next slot that reads the written word. Serialisation, clocking and the backplane side live outside this block.

Top module: `tsi_switch`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid`, `out_oe` and `out_data` are all zero, and the first slot after reset is channel 0 of frame 0.
- R2: Every cycle with `slot_en` high is one channel slot. The channel count runs 0..31 for `rate_sel` 0 and 3, 0..63 for 1 and 0..127 for 2, then wraps to 0 and starts a new frame. Cycles without `slot_en` do not advance it. `out_ch` reports the channel of each output slot.
- R3: When bit 12 (drive) of an output's control word is 0, that output's `out_oe` bit is 0 and its byte is 0x00 for the slot, whatever the other bits say. When bit 12 is 1, `out_oe` is 1.
- R4: With bit 12 set, bit 13 (message) set makes the output byte equal to bits 7..0 of the control word. This takes priority over switching and over sub-rate extraction.
- R5: With bit 14 set (constant delay), the switched byte is the one written to the source stream and channel during the previous frame, whatever the order of source and output channel.
- R6: With bit 14 clear (variable delay), the switched byte comes from the current frame if the source channel number is lower than the output channel, and from the previous frame otherwise (equal included).
- R7: Bit 15 set takes the source byte from the local input group (`loc_data`); bit 15 clear takes it from the alternate group (`alt_data`).
- R8: The source stream is given by bits 11..7 and the source channel by bits 6..0 of the control word. Only the low log2(streams) stream bits are used, and only the low 5, 6 or 7 channel bits at 32, 64 or 128 channels per frame.
- R9: In sub-rate mode (`rate_sel` 3), a non-message switched output carries one 2-bit field of the source byte in bits 1..0 and zeros above. Sub-rate word code 3 picks bits 7..6, 2 picks 5..4, 1 picks 3..2 and 0 picks 1..0. Bits 15..2 of the sub-rate word are ignored.
- R10: A connection-memory write takes effect from the next slot that reads that word: a later slot in the same frame sees the new word, and a slot reading the word in the very cycle of the write still uses the old word.
- R11: Each slot's result appears on the outputs one cycle after the `slot_en` cycle, with `out_valid` high. After a cycle without `slot_en`, `out_valid` and `out_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 2 | 0: 32 ch, 1: 64 ch, 2: 128 ch, 3: 32 ch sub-rate; static outside reset |
| slot_en | input | 1 | Marks a channel slot |
| loc_data | input | NSTR*8 | Local group input bytes, stream s at bits 8s+7..8s |
| alt_data | input | NSTR*8 | Alternate group input bytes, same layout |
| cm_we | input | 1 | Connection memory write strobe |
| cm_sel | input | 1 | 0: control word, 1: sub-rate word |
| cm_addr | input | log2(NSTR)+7 | {output stream, output channel} |
| cm_wdata | input | 16 | Word to write |
| out_valid | output | 1 | Output slot present |
| out_ch | output | 7 | Channel number of the output slot |
| out_oe | output | NSTR | Per-stream driver enable for the slot |
| out_data | output | NSTR*8 | Per-stream output bytes |

## Verification
Every switched, message or disabled byte, and the slot's channel number, is due exactly one clock after the `slot_en` cycle that carries the slot. The bench computes the expected values while it drives a slot and compares them at the next falling edge. Idle cycles are checked at the falling edge after them for a low `out_valid`. Frame-delay effects (R5, R6) become visible only once a whole frame has been written, so slot contents are compared from the second frame after each reset. Connection writes are placed in the same cycle as slots, so that both the same-cycle and later-slot timing of R10 show up at the outputs.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  localparam int CH_W   = 7;   // channel address width (128 channels max)
  localparam int SST_W  = 5;   // source stream field width in the control word
  localparam int WORD_W = 16;  // control / sub-rate word width

  typedef enum logic [1:0] {
    RATE_X1  = 2'd0,
    RATE_X2  = 2'd1,
    RATE_X4  = 2'd2,
    RATE_SUB = 2'd3
  } rate_e;

  typedef struct packed {
    logic             local_src;  // 1: local group, 0: alternate group
    logic             fixed_dly;  // 1: constant delay
    logic             msg;        // 1: emit low byte of the word
    logic             drive;      // 1: driver on
    logic [SST_W-1:0] src_st;
    logic [CH_W-1:0]  src_ch;
  } conn_t;

  // last channel index of a frame for a rate setting
  function automatic logic [CH_W-1:0] last_chan(input logic [1:0] r);
    case (r)
      RATE_X2: return CH_W'(63);
      RATE_X4: return CH_W'(127);
      default: return CH_W'(31);
    endcase
  endfunction

  function automatic logic [CH_W-1:0] mask_chan(input logic [CH_W-1:0] c,
                                                 input logic [1:0] r);
    return c & last_chan(r);
  endfunction

  // buffer to read: current write buffer only for variable delay with an
  // already written source channel
  function automatic logic read_buf(input logic fixed,
                                    input logic [CH_W-1:0] src,
                                    input logic [CH_W-1:0] cur,
                                    input logic wbuf);
    return (!fixed && (src < cur)) ? wbuf : !wbuf;
  endfunction

  function automatic logic [7:0] sub_pick(input logic [7:0] b,
                                          input logic [1:0] code);
    case (code)
      2'd3:    return {6'b0, b[7:6]};
      2'd2:    return {6'b0, b[5:4]};
      2'd1:    return {6'b0, b[3:2]};
      default: return {6'b0, b[1:0]};
    endcase
  endfunction

endpackage

// File: rtl/tsi_slot_ctr.sv
module tsi_slot_ctr
  import tsi_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      rate_sel,
  input  logic            slot_en,
  output logic [CH_W-1:0] ch_cnt,
  output logic            wr_buf,
  output logic            ch_last
);

  assign ch_last = (ch_cnt == last_chan(rate_sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_cnt <= '0;
      wr_buf <= 1'b0;
    end else if (slot_en) begin
      if (ch_last) begin
        ch_cnt <= '0;
        wr_buf <= !wr_buf;
      end else begin
        ch_cnt <= ch_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
  import tsi_pkg::*;
#(
  parameter int NSTR = 4
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic                     wbuf,
  input  logic [CH_W-1:0]          wch,
  input  logic [NSTR*8-1:0]        loc_in,
  input  logic [NSTR*8-1:0]        alt_in,
  input  logic [NSTR-1:0]          rd_buf,
  input  logic [NSTR-1:0]          rd_alt,
  input  logic [NSTR*$clog2(NSTR)-1:0] rd_st,
  input  logic [NSTR*CH_W-1:0]     rd_ch,
  output logic [NSTR*8-1:0]        rd_q
);

  localparam int SW    = $clog2(NSTR);
  localparam int AW    = 2 + SW + CH_W;
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  // all streams of both groups are written into the current buffer
  always_ff @(posedge clk) begin
    if (we) begin
      for (int s = 0; s < NSTR; s++) begin
        mem[{wbuf, 1'b0, SW'(s), wch}] <= loc_in[s*8 +: 8];
        mem[{wbuf, 1'b1, SW'(s), wch}] <= alt_in[s*8 +: 8];
      end
    end
  end

  for (genvar g = 0; g < NSTR; g++) begin : g_rd
    assign rd_q[g*8 +: 8] =
      mem[{rd_buf[g], rd_alt[g], rd_st[g*SW +: SW], rd_ch[g*CH_W +: CH_W]}];
  end

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
  import tsi_pkg::*;
#(
  parameter int NSTR = 4
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic                         sel,
  input  logic [$clog2(NSTR)+CH_W-1:0] addr,
  input  logic [WORD_W-1:0]            wdata,
  input  logic [CH_W-1:0]              rd_ch,
  output logic [NSTR*WORD_W-1:0]       conn_q,
  output logic [NSTR*WORD_W-1:0]       sub_q
);

  localparam int SW    = $clog2(NSTR);
  localparam int DEPTH = NSTR << CH_W;

  logic [WORD_W-1:0] conn_m [DEPTH];
  logic [WORD_W-1:0] sub_m  [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      if (sel) sub_m[addr]  <= wdata;
      else     conn_m[addr] <= wdata;
    end
  end

  // reads return the pre-write word in a write cycle
  for (genvar g = 0; g < NSTR; g++) begin : g_rd
    assign conn_q[g*WORD_W +: WORD_W] = conn_m[{SW'(g), rd_ch}];
    assign sub_q[g*WORD_W +: WORD_W]  = sub_m[{SW'(g), rd_ch}];
  end

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int NSTR = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   rate_sel,
  input  logic                         slot_en,
  input  logic [NSTR*8-1:0]            loc_data,
  input  logic [NSTR*8-1:0]            alt_data,
  input  logic                         cm_we,
  input  logic                         cm_sel,
  input  logic [$clog2(NSTR)+CH_W-1:0] cm_addr,
  input  logic [WORD_W-1:0]            cm_wdata,
  output logic                         out_valid,
  output logic [CH_W-1:0]              out_ch,
  output logic [NSTR-1:0]              out_oe,
  output logic [NSTR*8-1:0]            out_data
);

  localparam int SW = $clog2(NSTR);

  logic [CH_W-1:0] ch_cnt;
  logic            wr_buf;
  logic            ch_last;

  tsi_slot_ctr u_ctr (
    .clk      (clk),
    .rst      (rst),
    .rate_sel (rate_sel),
    .slot_en  (slot_en),
    .ch_cnt   (ch_cnt),
    .wr_buf   (wr_buf),
    .ch_last  (ch_last)
  );

  logic [NSTR*WORD_W-1:0] cw_flat;
  logic [NSTR*WORD_W-1:0] sw_flat;

  tsi_conn_mem #(.NSTR(NSTR)) u_cm (
    .clk    (clk),
    .we     (cm_we),
    .sel    (cm_sel),
    .addr   (cm_addr),
    .wdata  (cm_wdata),
    .rd_ch  (ch_cnt),
    .conn_q (cw_flat),
    .sub_q  (sw_flat)
  );

  logic [NSTR-1:0]      rd_buf;
  logic [NSTR-1:0]      rd_alt;
  logic [NSTR*SW-1:0]   rd_st;
  logic [NSTR*CH_W-1:0] rd_ch;
  logic [NSTR*8-1:0]    rd_q;

  tsi_data_mem #(.NSTR(NSTR)) u_dm (
    .clk    (clk),
    .we     (slot_en),
    .wbuf   (wr_buf),
    .wch    (ch_cnt),
    .loc_in (loc_data),
    .alt_in (alt_data),
    .rd_buf (rd_buf),
    .rd_alt (rd_alt),
    .rd_st  (rd_st),
    .rd_ch  (rd_ch),
    .rd_q   (rd_q)
  );

  logic [NSTR*8-1:0] slot_byte;
  logic [NSTR-1:0]   slot_oe;

  for (genvar g = 0; g < NSTR; g++) begin : g_out
    conn_t             cw;
    logic [WORD_W-1:0] sw;
    logic [CH_W-1:0]   src_ch;
    logic [7:0]        fmt_b;
    logic              unused_cfg;

    assign cw     = conn_t'(cw_flat[g*WORD_W +: WORD_W]);
    assign sw     = sw_flat[g*WORD_W +: WORD_W];
    assign src_ch = mask_chan(cw.src_ch, rate_sel);

    assign rd_ch[g*CH_W +: CH_W] = src_ch;
    assign rd_st[g*SW +: SW]     = cw.src_st[SW-1:0];
    assign rd_alt[g]             = !cw.local_src;
    assign rd_buf[g]             = read_buf(cw.fixed_dly, src_ch, ch_cnt, wr_buf);

    // drive off beats message, message beats sub-rate extraction
    always_comb begin
      fmt_b = rd_q[g*8 +: 8];
      if (rate_sel == RATE_SUB) fmt_b = sub_pick(fmt_b, sw[1:0]);
      if (cw.msg)               fmt_b = cw_flat[g*WORD_W +: 8];
      if (!cw.drive)            fmt_b = 8'h00;
    end

    assign slot_byte[g*8 +: 8] = fmt_b;
    assign slot_oe[g]          = cw.drive;
    assign unused_cfg          = ^{cw.src_st[SST_W-1:SW], sw[WORD_W-1:2]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_oe    <= '0;
      out_data  <= '0;
    end else if (slot_en) begin
      out_valid <= 1'b1;
      out_ch    <= ch_cnt;
      out_oe    <= slot_oe;
      out_data  <= slot_byte;
    end else begin
      out_valid <= 1'b0;
      out_oe    <= '0;
      out_data  <= '0;
    end
  end

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
  import tsi_pkg::*;
#(
  parameter int NSTR = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        rate_sel,
  input logic              slot_en,
  input logic [CH_W-1:0]   ch_cnt,
  input logic              wr_buf,
  input logic              ch_last,
  input logic              out_valid,
  input logic [CH_W-1:0]   out_ch,
  input logic [NSTR-1:0]   out_oe,
  input logic [NSTR*8-1:0] out_data
);

  logic [NSTR*8-1:0] oe_bits;
  always_comb begin
    for (int i = 0; i < NSTR; i++) oe_bits[i*8 +: 8] = {8{out_oe[i]}};
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!out_valid && out_oe == '0 && out_data == '0 && ch_cnt == '0));

  a_r2_wrap_new_frame: assert property (@(posedge clk) disable iff (rst)
    (slot_en && ch_last) |=> (ch_cnt == '0 && wr_buf != $past(wr_buf)));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !slot_en |=> ($stable(ch_cnt) && $stable(wr_buf)));

  a_r2_ch_in_frame: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_ch <= last_chan(rate_sel)));

  a_r3_off_is_zero: assert property (@(posedge clk) disable iff (rst)
    (out_data & ~oe_bits) == '0);

  a_r11_slot_valid: assert property (@(posedge clk) disable iff (rst)
    slot_en |=> out_valid);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !slot_en |=> (!out_valid && out_oe == '0));

endmodule

bind tsi_switch tsi_switch_chk #(.NSTR(NSTR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rate_sel  (rate_sel),
  .slot_en   (slot_en),
  .ch_cnt    (ch_cnt),
  .wr_buf    (wr_buf),
  .ch_last   (ch_last),
  .out_valid (out_valid),
  .out_ch    (out_ch),
  .out_oe    (out_oe),
  .out_data  (out_data)
);

// File: tb/tsi_switch_test.sv
`timescale 1ns/1ps
module tsi_switch_test;

  localparam int NS = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [1:0]     rate_sel = 2'd0;
  logic           slot_en = 1'b0;
  logic [NS*8-1:0] loc_data = '0;
  logic [NS*8-1:0] alt_data = '0;
  logic           cm_we = 1'b0;
  logic           cm_sel = 1'b0;
  logic [8:0]     cm_addr = '0;
  logic [15:0]    cm_wdata = '0;
  logic           out_valid;
  logic [6:0]     out_ch;
  logic [NS-1:0]  out_oe;
  logic [NS*8-1:0] out_data;

  always #10 clk = !clk;  // 50 MHz

  tsi_switch #(.NSTR(NS)) uut (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .slot_en(slot_en),
    .loc_data(loc_data), .alt_data(alt_data), .cm_we(cm_we), .cm_sel(cm_sel),
    .cm_addr(cm_addr), .cm_wdata(cm_wdata), .out_valid(out_valid),
    .out_ch(out_ch), .out_oe(out_oe), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // stimulus / expected-behaviour table
  typedef struct packed {
    logic [1:0]  ph;
    logic [1:0]  st;
    logic [6:0]  ch;
    logic [15:0] cw;
    logic [15:0] sw;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 7'd5,   16'hC005, 16'h0000, 4'd3},
    '{2'd0, 2'd3, 7'd0,   16'h2055, 16'h0000, 4'd3},
    '{2'd0, 2'd1, 7'd6,   16'hB0A5, 16'h0000, 4'd4},
    '{2'd0, 2'd2, 7'd7,   16'hD194, 16'h0000, 4'd5},
    '{2'd0, 2'd3, 7'd10,  16'h9003, 16'h0000, 4'd6},
    '{2'd0, 2'd3, 7'd11,  16'h9099, 16'h0000, 4'd6},
    '{2'd0, 2'd0, 7'd12,  16'h910C, 16'h0000, 4'd6},
    '{2'd0, 2'd0, 7'd31,  16'h901E, 16'h0000, 4'd6},
    '{2'd0, 2'd1, 7'd13,  16'h5104, 16'h0000, 4'd7},
    '{2'd0, 2'd2, 7'd20,  16'h1182, 16'h0000, 4'd7},
    '{2'd0, 2'd2, 7'd14,  16'hDEFF, 16'h0000, 4'd8},
    '{2'd1, 2'd0, 7'd40,  16'hD0BF, 16'h0000, 4'd2},
    '{2'd1, 2'd1, 7'd63,  16'h90BE, 16'h0000, 4'd6},
    '{2'd1, 2'd2, 7'd50,  16'hD17F, 16'h0000, 4'd8},
    '{2'd2, 2'd0, 7'd127, 16'hD1FF, 16'h0000, 4'd2},
    '{2'd2, 2'd1, 7'd100, 16'hD305, 16'h0000, 4'd8},
    '{2'd3, 2'd0, 7'd1,   16'hD001, 16'hFFF1, 4'd9},
    '{2'd3, 2'd0, 7'd3,   16'hD003, 16'h7FF7, 4'd9},
    '{2'd3, 2'd1, 7'd4,   16'hB03C, 16'h0003, 4'd4}
  };

  function automatic string tag_name(input logic [3:0] n);
    case (n)
      4'd2: return "R2";  4'd3: return "R3";  4'd4: return "R4";
      4'd5: return "R5";  4'd6: return "R6";  4'd7: return "R7";
      4'd8: return "R8";  4'd9: return "R9";  default: return "R10";
    endcase
  endfunction

  // bench-side shadow of the connection memory
  logic [15:0] conn_sh [NS][128];
  logic [15:0] sub_sh  [NS][128];
  string       tag_sh  [NS][128];
  int          rt = 0;
  int          phase = 0;
  int          fr = 0;
  int          chn = 0;

  function automatic int nch(input int r);
    return (r == 1) ? 64 : (r == 2) ? 128 : 32;
  endfunction

  function automatic logic [7:0] dval(input int f, input int a, input int s, input int c);
    return 8'((c * 5 + s * 37 + a * 101 + f * 71 + 13) % 256);
  endfunction

  // expected {oe, byte} for an output stream / channel in frame f
  function automatic logic [8:0] model(input int os, input int oc, input int f);
    logic [15:0] w;
    logic [15:0] u;
    logic [7:0]  b;
    int          a, st, c, sf;
    w = conn_sh[os][oc];
    u = sub_sh[os][oc];
    if (!w[12]) return 9'h000;
    if (w[13])  return {1'b1, w[7:0]};
    a  = w[15] ? 0 : 1;
    st = int'(w[8:7]);
    c  = int'(w[6:0]) % nch(rt);
    sf = (!w[14] && c < oc) ? f : f - 1;
    b  = dval(sf, a, st, c);
    if (rt == 3) begin
      case (u[1:0])
        2'd3: b = {6'b0, b[7:6]};
        2'd2: b = {6'b0, b[5:4]};
        2'd1: b = {6'b0, b[3:2]};
        default: b = {6'b0, b[1:0]};
      endcase
    end
    return {1'b1, b};
  endfunction

  bit         pend = 0, pend_full = 0, idle_chk = 0;
  int         pend_ch = 0;
  logic [7:0] exp_d  [NS];
  logic       exp_oe [NS];
  string      exp_tag[NS];

  task automatic cm_write(input logic sel, input int s, input int c, input logic [15:0] d);
    @(negedge clk);
    slot_en  = 1'b0;
    cm_we    = 1'b1;
    cm_sel   = sel;
    cm_addr  = {2'(s), 7'(c)};
    cm_wdata = d;
    @(negedge clk);
    cm_we = 1'b0;
  endtask

  task automatic step(input bit act);
    @(negedge clk);
    if (pend) begin
      chk(out_valid == 1'b1, "R11", "out_valid in slot", int'(out_valid), 1);
      chk(out_ch == 7'(pend_ch), "R2", "out_ch", int'(out_ch), pend_ch);
      if (pend_full) begin
        for (int s = 0; s < NS; s++) begin
          chk(out_oe[s] == exp_oe[s], exp_tag[s], $sformatf("oe s%0d ch%0d", s, pend_ch),
              int'(out_oe[s]), int'(exp_oe[s]));
          chk(out_data[s*8 +: 8] == exp_d[s], exp_tag[s],
              $sformatf("byte s%0d ch%0d fr%0d", s, pend_ch, fr),
              int'(out_data[s*8 +: 8]), int'(exp_d[s]));
        end
      end
    end else if (idle_chk) begin
      chk(!out_valid && out_oe == '0, "R11", "idle cycle quiet",
          int'({out_valid, out_oe}), 0);
    end
    cm_we = 1'b0;
    if (act) begin
      for (int s = 0; s < NS; s++) begin
        logic [8:0] m;
        loc_data[s*8 +: 8] = dval(fr, 0, s, chn);
        alt_data[s*8 +: 8] = dval(fr, 1, s, chn);
        m = model(s, chn, fr);
        exp_oe[s]  = m[8];
        exp_d[s]   = m[7:0];
        exp_tag[s] = tag_sh[s][chn];
      end
      slot_en   = 1'b1;
      pend      = 1;
      pend_ch   = chn;
      pend_full = (fr >= 1);
      idle_chk  = 0;
      // R10: writes issued in the same cycle as a slot
      if (phase == 0 && fr == 2 && chn == 8) begin
        cm_we = 1'b1; cm_sel = 1'b0; cm_addr = {2'd0, 7'd18}; cm_wdata = 16'hB0C3;
        conn_sh[0][18] = 16'hB0C3; tag_sh[0][18] = "R10";
      end
      if (phase == 0 && fr == 2 && chn == 9) begin
        cm_we = 1'b1; cm_sel = 1'b0; cm_addr = {2'd1, 7'd9}; cm_wdata = 16'hB01E;
        conn_sh[1][9] = 16'hB01E; tag_sh[1][9] = "R10";
      end
      if (chn == nch(rt) - 1) begin
        chn = 0;
        fr++;
      end else begin
        chn++;
      end
    end else begin
      slot_en  = 1'b0;
      pend     = 0;
      idle_chk = 1;
    end
  endtask

  task automatic do_reset(input int r);
    @(negedge clk);
    rst = 1'b1; slot_en = 1'b0; cm_we = 1'b0;
    rate_sel = 2'(r);
    rt = r;
    @(negedge clk);
    @(negedge clk);
    chk(!out_valid && out_oe == '0 && out_data == '0, "R1", "outputs in reset",
        int'({out_valid, out_oe}) | int'(out_data != '0), 0);
    rst = 1'b0;
    pend = 0; idle_chk = 0; fr = 0; chn = 0;
  endtask

  task automatic program_phase(input int p);
    for (int s = 0; s < NS; s++) begin
      for (int c = 0; c < nch(rt); c++) begin
        conn_sh[s][c] = 16'hD000 | 16'(s << 7) | 16'(c);
        sub_sh[s][c]  = 16'h0000;
        tag_sh[s][c]  = (rt == 3) ? "R9" : "R5";
        cm_write(1'b0, s, c, conn_sh[s][c]);
        cm_write(1'b1, s, c, 16'h0000);
      end
    end
    for (int i = 0; i < NV; i++) begin
      if (int'(VECS[i].ph) == p) begin
        conn_sh[VECS[i].st][VECS[i].ch] = VECS[i].cw;
        sub_sh[VECS[i].st][VECS[i].ch]  = VECS[i].sw;
        tag_sh[VECS[i].st][VECS[i].ch]  = tag_name(VECS[i].tag);
        cm_write(1'b0, int'(VECS[i].st), int'(VECS[i].ch), VECS[i].cw);
        cm_write(1'b1, int'(VECS[i].st), int'(VECS[i].ch), VECS[i].sw);
      end
    end
  endtask

  task automatic run_frames(input int nf);
    for (int f = 0; f < nf; f++) begin
      for (int c = 0; c < nch(rt); c++) begin
        step(1);
        if (c % 11 == 10) step(0);
      end
    end
    step(0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rates [4] = '{0, 1, 2, 3};
    int nfr   [4] = '{4, 2, 2, 2};
    for (int p = 0; p < 4; p++) begin
      phase = p;
      do_reset(rates[p]);
      program_phase(p);
      run_frames(nfr[p]);
    end
    // R1: reset after activity clears outputs and restarts at channel 0
    do_reset(0);
    step(1);
    step(0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule